// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Match

A free-running 64-bit up-counter that sits behind a 32-bit word-addressed register port. A programmable divider sets how many input clocks make one count step. A 64-bit comparator watches the count. When the two are equal, a sticky event flag is raised. If automatic stepping is switched on, the comparator is moved forward by a programmable step in the same cycle, so the next match follows without software rewriting it. Periodic events therefore need no software action beyond clearing the flag.

Software reads the count as two 32-bit words. Reading the low word also captures the upper half into a shadow, and a later read of the high word returns that shadow. A 64-bit value assembled from the two reads is therefore consistent even if a carry crosses between the reads. The count can be preset only while the timer is stopped. One level interrupt output reports the flag, gated by an enable bit.

Top module: `cmp_timer64`

## Requirements
- R1: After reset the count, comparator, step value, control word and event flag are all zero, and `irq_o` is low.
- R2: While control bit 0 is set, the count rises by one every (P+1) clocks, where P is control bits 15:8. The count starts its divider phase afresh each time it is enabled. While bit 0 is clear, the count holds.
- R3: The count is a true 64-bit value: a step from low word 0xFFFFFFFF carries into the high word.
- R4: Writes to byte offset 0x00 (count low) and 0x04 (count high) load the count only while control bit 0 is clear. They are ignored while it is set.
- R5: A read of offset 0x04 returns the upper 32 count bits as they stood at the most recent read of offset 0x00.
- R6: While control bit 1 is set and the count equals the comparator (low at 0x10, high at 0x14), status bit 0 (offset 0x0C) becomes set on the next clock.
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R8: `irq_o` is the registered AND of the event flag and control bit 2. It follows one clock after either input changes.
- R9: When control bit 3 and bit 1 are both set, each match adds the step register (offset 0x18) to the 64-bit comparator on the same clock. A software write to the comparator in that cycle takes priority.
- R10: Reads return the comparator words, the step value, the status word (flag in bit 0, zero elsewhere) and the control word (bits 3:0 and 15:8, all others zero). `bus_rdata` is valid on the clock after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 5 | Byte offset of the register (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the clock after `bus_rd` |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The counting path is tried with random preset values, divider settings from 0 to 3 and random run lengths. Some presets are placed near the 32-bit boundary, so one pattern separates divider phase errors from carry errors. A directed run starts just below a carry and reads the low word before the carry and the high word after it, which shows whether the shadow or the live high word is returned. Random comparator start points and steps are run with automatic stepping, and the final comparator is predicted from the number of matches crossed, which separates missed steps from double steps. Directed sequences cover writes of 0 and 1 to the flag, the interrupt mask in both directions, and count writes issued while the timer runs.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  // word index of each register (byte offset / 4)
  localparam int REG_CNT_LO = 0;
  localparam int REG_CNT_HI = 1;
  localparam int REG_CTRL   = 2;
  localparam int REG_STAT   = 3;
  localparam int REG_CMP_LO = 4;
  localparam int REG_CMP_HI = 5;
  localparam int REG_STEP   = 6;
  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_CMP   = 1;
  localparam int CB_IE    = 2;
  localparam int CB_AUTO  = 3;
  localparam int CB_NBITS = 4;
  localparam int DIV_LSB  = 8;
endpackage

// File: rtl/cmpt_divider.sv
module cmpt_divider #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] div,
  output logic          step
);
  logic [PW-1:0] phase_q;

  assign step = run && (phase_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run)
      phase_q <= '0;
    else if (phase_q == div)
      phase_q <= '0;
    else
      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [DW-1:0]   ld_data,
  output logic [2*DW-1:0] value
);
  localparam int CW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst)
      value <= '0;
    else if (ld_lo)
      value[DW-1:0] <= ld_data;
    else if (ld_hi)
      value[CW-1:DW] <= ld_data;
    else if (step)
      value <= value + 1'b1;
  end
endmodule

// File: rtl/cmpt_match.sv
module cmpt_match #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*DW-1:0] count,
  input  logic            cmp_on,
  input  logic            auto_on,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_step,
  input  logic            clr,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] cmp,
  output logic [DW-1:0]   step_val,
  output logic            flag
);
  localparam int CW = 2 * DW;
  logic hit;

  assign hit = cmp_on && (count == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp      <= '0;
      step_val <= '0;
      flag     <= 1'b0;
    end else begin
      if (wr_lo)
        cmp[DW-1:0] <= wdata;
      else if (wr_hi)
        cmp[CW-1:DW] <= wdata;
      else if (hit && auto_on)
        cmp <= cmp + CW'(step_val);

      if (wr_step)
        step_val <= wdata;

      if (hit)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import cmpt_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int CW = 2 * DW;
  localparam int IW = AW - 2;

  logic [CB_NBITS-1:0] ctrl_q;
  logic [PW-1:0]       div_q;
  logic [DW-1:0]       shadow_q;
  logic [IW-1:0]       widx;
  logic                aligned;
  logic                en_q, cmp_en_q, ie_q, auto_q;
  logic                step;
  logic                cnt_wr_lo, cnt_wr_hi, cnt_wr, cmp_wr;
  logic [CW-1:0]       cnt_val, cmp_val;
  logic [DW-1:0]       inc_val;
  logic                flag_q;
  logic [DW-1:0]       rd_mux, ctrl_rd;

  assign widx     = bus_addr[AW-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign en_q     = ctrl_q[CB_RUN];
  assign cmp_en_q = ctrl_q[CB_CMP];
  assign ie_q     = ctrl_q[CB_IE];
  assign auto_q   = ctrl_q[CB_AUTO];

  function automatic logic wr_at(input int idx);
    return bus_wr && aligned && (widx == IW'(idx));
  endfunction

  assign cnt_wr_lo = wr_at(REG_CNT_LO) && !en_q;
  assign cnt_wr_hi = wr_at(REG_CNT_HI) && !en_q;
  assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;
  assign cmp_wr    = wr_at(REG_CMP_LO) || wr_at(REG_CMP_HI);

  cmpt_divider #(.PW(PW)) u_div (
    .clk(clk), .rst(rst), .run(en_q), .div(div_q), .step(step)
  );

  cmpt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .step(step),
    .ld_lo(cnt_wr_lo), .ld_hi(cnt_wr_hi), .ld_data(bus_wdata),
    .value(cnt_val)
  );

  cmpt_match #(.DW(DW)) u_match (
    .clk(clk), .rst(rst), .count(cnt_val),
    .cmp_on(cmp_en_q), .auto_on(auto_q),
    .wr_lo(wr_at(REG_CMP_LO)), .wr_hi(wr_at(REG_CMP_HI)),
    .wr_step(wr_at(REG_STEP)),
    .clr(wr_at(REG_STAT) && bus_wdata[0]),
    .wdata(bus_wdata),
    .cmp(cmp_val), .step_val(inc_val), .flag(flag_q)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_NBITS-1:0] = ctrl_q;
    ctrl_rd[DIV_LSB +: PW] = div_q;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if      (widx == IW'(REG_CNT_LO)) rd_mux = cnt_val[DW-1:0];
      else if (widx == IW'(REG_CNT_HI)) rd_mux = shadow_q;
      else if (widx == IW'(REG_CTRL))   rd_mux = ctrl_rd;
      else if (widx == IW'(REG_STAT))   rd_mux = DW'(flag_q);
      else if (widx == IW'(REG_CMP_LO)) rd_mux = cmp_val[DW-1:0];
      else if (widx == IW'(REG_CMP_HI)) rd_mux = cmp_val[CW-1:DW];
      else if (widx == IW'(REG_STEP))   rd_mux = inc_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      shadow_q  <= '0;
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (wr_at(REG_CTRL)) begin
        ctrl_q <= bus_wdata[CB_NBITS-1:0];
        div_q  <= bus_wdata[DIV_LSB +: PW];
      end
      if (bus_rd) begin
        bus_rdata <= rd_mux;
        if (aligned && widx == IW'(REG_CNT_LO))
          shadow_q <= cnt_val[CW-1:DW];
      end
      irq_o <= flag_q && ie_q;
    end
  end
endmodule

// File: rtl/cmpt_checker.sv
module cmpt_checker #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_o,
  input logic            flag_q,
  input logic            en_q,
  input logic            cmp_en_q,
  input logic            ie_q,
  input logic            auto_q,
  input logic            cnt_wr,
  input logic            cmp_wr,
  input logic [2*DW-1:0] cnt_val,
  input logic [2*DW-1:0] cmp_val,
  input logic [DW-1:0]   inc_val
);
  localparam int CW = 2 * DW;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_wr) |=> $stable(cnt_val));

  assert_wr_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    en_q |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + CW'(1)));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_en_q && cnt_val == cmp_val) |=> flag_q);

  assert_irq_on_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ie_q) |=> irq_o);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    !(flag_q && ie_q) |=> !irq_o);

  assert_autostep_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_en_q && auto_q && cnt_val == cmp_val && !cmp_wr)
      |=> cmp_val == $past(cmp_val) + CW'($past(inc_val)));
endmodule

bind cmp_timer64 cmpt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .flag_q(flag_q),
  .en_q(en_q), .cmp_en_q(cmp_en_q), .ie_q(ie_q), .auto_q(auto_q),
  .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
  .cnt_val(cnt_val), .cmp_val(cmp_val), .inc_val(inc_val)
);

// File: tb/test_cmp_timer64.sv
`timescale 1ns/1ps
module test_cmp_timer64;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                         A_STA = 5'h0C, A_MLO = 5'h10, A_MHI = 5'h14,
                         A_STP = 5'h18;

  always #2 clk = ~clk;

  cmp_timer64 i_cmp_timer64 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    br(A_CLO, lo);
    br(A_CHI, hi);
    v = {hi, lo};
  endtask

  function automatic logic [63:0] exp_count(input logic [63:0] c, input int n, input int p);
    return c + 64'((n + 1) / (p + 1));
  endfunction

  function automatic logic [63:0] exp_cmp(input logic [63:0] c0, input logic [31:0] inc, input int last);
    logic [63:0] c = c0;
    while (c <= 64'(last)) c = c + 64'(inc);
    return c;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, c;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd64(v); chk("R1 count", v, 0);
    br(A_CTL, d); chk("R1 ctrl", d, 0);
    br(A_STA, d); chk("R1 flag", d, 0);
    br(A_MLO, d); chk("R1 cmp lo", d, 0);
    br(A_STP, d); chk("R1 step", d, 0);
    chk("R1 irq", irq_o, 0);

    // R10 readback
    bw(A_CTL, 32'hFFFF_FFF0); br(A_CTL, d); chk("R10 ctrl mask", d, 32'h0000_FF00);
    bw(A_CTL, 0);
    bw(A_MHI, 32'hA5A5_1234); br(A_MHI, d); chk("R10 cmp hi", d, 32'hA5A5_1234);
    bw(A_STP, 32'h0BAD_F00D); br(A_STP, d); chk("R10 step", d, 32'h0BAD_F00D);
    bw(A_MHI, 0);

    // R2 R3 random counting runs
    for (int it = 0; it < 12; it++) begin
      int p = $urandom % 4;
      int n = $urandom % 40;
      c = {32'($urandom % 4), (it % 2) ? 32'hFFFF_FFE0 + 32'($urandom % 16) : $urandom};
      bw(A_CLO, c[31:0]); bw(A_CHI, c[63:32]);
      bw(A_CTL, 32'(p << 8) | 32'h1);
      repeat (n) @(negedge clk);
      bw(A_CTL, 0);
      rd64(v); chk("R2 R3 count run", v, exp_count(c, n, p));
      repeat (10) @(negedge clk);
      rd64(v); chk("R2 hold when stopped", v, exp_count(c, n, p));
    end

    // R5 coherent read across a carry, R3 carry
    bw(A_CLO, 32'hFFFF_FFF0); bw(A_CHI, 32'h5);
    bw(A_CTL, 1);
    br(A_CLO, d);
    repeat (40) @(negedge clk);
    br(A_CHI, d); chk("R5 shadow high", d, 32'h5);
    bw(A_CTL, 0);
    rd64(v); chk("R3 carry count", v, 64'h6_0000_001B);

    // R4 count writes ignored while running
    bw(A_CLO, 1000); bw(A_CHI, 0);
    bw(A_CTL, 1);
    bw(A_CLO, 0); bw(A_CHI, 32'h77);
    bw(A_CTL, 0);
    rd64(v); chk("R4 writes ignored", v, 64'd1003);

    // R6 R8 match raises flag and irq
    bw(A_CLO, 100); bw(A_CHI, 0);
    bw(A_MLO, 105); bw(A_MHI, 0);
    bw(A_CTL, 32'h7);
    repeat (20) @(negedge clk);
    chk("R8 irq on match", irq_o, 1);
    br(A_STA, d); chk("R6 flag set", d, 1);
    bw(A_CTL, 32'h4);
    // R7 write 0 keeps, write 1 clears
    bw(A_STA, 0); br(A_STA, d); chk("R7 write0 keeps", d, 1);
    bw(A_STA, 1); br(A_STA, d); chk("R7 write1 clears", d, 0);
    chk("R8 irq drops", irq_o, 0);
    // R7 set wins over clear: match held while clearing
    bw(A_CLO, 50); bw(A_MLO, 50);
    bw(A_CTL, 32'h2);
    bw(A_STA, 1); br(A_STA, d); chk("R7 set wins", d, 1);
    chk("R8 masked irq", irq_o, 0);
    bw(A_CTL, 32'h6); @(negedge clk);
    chk("R8 unmasked irq", irq_o, 1);
    bw(A_CTL, 0); bw(A_STA, 1);

    // R9 auto-step runs
    for (int it = 0; it < 5; it++) begin
      int n = 20 + $urandom % 40;
      logic [31:0] inc = 1 + $urandom % 9;
      logic [63:0] c0 = 64'(3 + $urandom % 10);
      bw(A_CLO, 0); bw(A_CHI, 0);
      bw(A_MLO, c0[31:0]); bw(A_MHI, 0);
      bw(A_STP, inc);
      bw(A_CTL, 32'hB);
      repeat (n) @(negedge clk);
      bw(A_CTL, 0);
      br(A_MLO, d); v[31:0] = d;
      br(A_MHI, d); v[63:32] = d;
      chk("R9 auto-step cmp", v, exp_cmp(c0, inc, n));
      rd64(v); chk("R2 count after run", v, 64'(n + 1));
      bw(A_STA, 1);
    end

    finish_run();
  end
endmodule